// File: doc/BRIEF.md
# DMA Channel Stop Control

This block is one channel of a DMA engine. It moves single data beats from a source to a destination through a small internal FIFO. The source signals that data is ready with a request line, and the channel reads it with a read strobe that is held until the source acknowledges the beat. The destination side uses the same kind of strobe and acknowledge. A transfer count gives the number of source beats. A controller-wide enable input gates all transfer activity.

Software controls the channel through a write port with two targets. The control word holds the enable bit and the halt bit. The count word loads the number of beats. Three status outputs mirror enable, halt and a flag that shows whether data is still waiting in the FIFO. The channel can stop in three ways. An abrupt disable throws away whatever the FIFO holds. A halt stops taking new source beats but keeps draining, so the channel can then be disabled with nothing lost. When the count runs out and the FIFO is empty, the channel shuts itself down and raises a done pulse.

Top module: `dmach_channel`

## Requirements
- R1: While `glb_en` is 0, the channel starts no source read and no destination write, even with its enable bit set. The enable bit still reads back as set on `st_enable`.
- R2: After a count is loaded and the control word is written with bit 0 (enable) at 1, every source beat reaches the destination exactly once and in source order.
- R3: The FIFO holds `DEPTH` entries. `src_rd` is not raised while the FIFO is full. `st_active` is 1 exactly when the FIFO holds data.
- R4: Once control bit 1 (halt) is set, a source beat already in progress completes. No new `src_rd` is raised while halt stays set.
- R5: While halted, the destination keeps draining, so `st_active` falls to 0. Disabling after that loses no beat and raises no done pulse.
- R6: Clearing halt while enable is still set resumes source reads from the remaining count. The total number of source beats then equals the loaded count.
- R7: Writing the control word with enable at 0 clears `st_enable` on the next cycle. An in-flight beat completes, and the FIFO is emptied in the cycle it completes. Data still held in the FIFO is never written to the destination.
- R8: When all counted beats have been written and the FIFO is empty, the channel clears its own enable and raises `done` for exactly one cycle. A count of 0 completes at once.
- R9: A count-word write (`reg_sel` = 1) while enable is 1 is ignored.
- R10: An abrupt disable raises no `done` pulse.
- R11: `src_rd` is held until `src_ack`. `dst_wr` is held with stable `dst_data` until `dst_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Controller-wide enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: control word (bit 0 enable, bit 1 halt), 1: count word |
| reg_wdata | input | CNT_W | Write data |
| st_enable | output | 1 | Channel enable status |
| st_halt | output | 1 | Halt status |
| st_active | output | 1 | FIFO holds undelivered data |
| beats_left | output | CNT_W | Source beats not yet issued |
| src_req | input | 1 | Source has data ready |
| src_rd | output | 1 | Source read strobe |
| src_ack | input | 1 | Source beat complete, data valid |
| src_data | input | DW | Source data |
| dst_wr | output | 1 | Destination write strobe |
| dst_ack | input | 1 | Destination beat complete |
| dst_data | output | DW | Destination data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the channel with `DEPTH` = 4, `CNT_W` = 8 and `DW` = 8. With a FIFO this shallow, holding the destination back fills the FIFO within a few beats, so the full-FIFO stall and a discard of a full FIFO are both easy to reach. An 8-bit count allows transfers long enough to halt midway, resume, and still see the exact beat total. Random source and destination latencies of zero to three cycles place halt and disable writes at many points relative to beats in flight.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_COUNT = 1'b1
   } reg_sel_e;

   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_HALT_BIT = 1;
endpackage

// File: rtl/dmach_fifo.sv
module dmach_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         full,
   output logic                         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH+1);
   localparam bit POW2 = (DEPTH == (1 << PW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dmach_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap_any
         assign wr_nxt = (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      level <= level + LW'(1);
         else if (pop && !push) level <= level - LW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= push_data;
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> (!full || pop));
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |-> !empty);
   p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
endmodule

// File: rtl/dmach_src.sv
module dmach_src #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             room,
   input  logic             src_req,
   input  logic             src_ack,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             src_rd,
   output logic             push,
   output logic [CNT_W-1:0] left
);
   logic busy, start;

   assign start  = run && src_req && !busy && room && (left != '0);
   assign push   = busy && src_ack;
   assign src_rd = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else begin
         if (start)     busy <= 1'b1;
         else if (push) busy <= 1'b0;
         if (load)       left <= load_val;
         else if (start) left <= left - CNT_W'(1);
      end
   end

   p_rd_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rd && !src_ack) |=> src_rd);
   p_halt_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_rd) |-> $past(run && room));
endmodule

// File: rtl/dmach_dst.sv
module dmach_dst #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          avail,
   input  logic [DW-1:0] head,
   input  logic          dst_ack,
   output logic          dst_wr,
   output logic          pop,
   output logic [DW-1:0] dst_data
);
   logic busy, start;

   assign start    = run && avail && !busy;
   assign pop      = busy && dst_ack;
   assign dst_wr   = busy;
   assign dst_data = head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (pop)   busy <= 1'b0;
   end

   p_wr_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_wr && !dst_ack) |=> (dst_wr && $stable(dst_data)));
endmodule

// File: rtl/dmach_channel.sv
module dmach_channel #(
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic             st_enable,
   output logic             st_halt,
   output logic             st_active,
   output logic [CNT_W-1:0] beats_left,
   input  logic             src_req,
   output logic             src_rd,
   input  logic             src_ack,
   input  logic [DW-1:0]    src_data,
   output logic             dst_wr,
   input  logic             dst_ack,
   output logic [DW-1:0]    dst_data,
   output logic             done
);
   import dmach_pkg::*;

   localparam int LW = $clog2(DEPTH+1);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("dmach_channel: CNT_W must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dmach_channel: DW must be at least 1");
      end
   endgenerate

   reg_sel_e      sel;
   logic          en_q, halt_q, done_q;
   logic          ctl_wr, cnt_load, finish, flush;
   logic          push, pop, fifo_full, fifo_empty;
   logic          src_run, dst_run;
   logic [DW-1:0] head;
   logic [LW-1:0] level;

   assign sel      = reg_sel_e'(reg_sel);
   assign ctl_wr   = reg_wr && (sel == SEL_CTRL);
   assign cnt_load = reg_wr && (sel == SEL_COUNT) && !en_q;
   assign src_run  = en_q && glb_en && !halt_q;
   assign dst_run  = en_q && glb_en;
   assign finish   = en_q && glb_en && (beats_left == '0) && !src_rd
                     && !dst_wr && fifo_empty;
   assign flush    = !en_q && (!src_rd || src_ack) && (!dst_wr || dst_ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         halt_q <= 1'b0;
         done_q <= 1'b0;
      end else if (ctl_wr) begin
         en_q   <= reg_wdata[CTL_EN_BIT];
         halt_q <= reg_wdata[CTL_HALT_BIT];
         done_q <= 1'b0;
      end else if (finish) begin
         en_q   <= 1'b0;
         done_q <= 1'b1;
      end else begin
         done_q <= 1'b0;
      end
   end

   dmach_src #(.CNT_W(CNT_W)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (src_run),
      .room     (!fifo_full),
      .src_req  (src_req),
      .src_ack  (src_ack),
      .load     (cnt_load),
      .load_val (reg_wdata),
      .src_rd   (src_rd),
      .push     (push),
      .left     (beats_left)
   );

   dmach_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (push),
      .push_data (src_data),
      .pop       (pop),
      .head      (head),
      .level     (level),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   dmach_dst #(.DW(DW)) u_dst (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (dst_run),
      .avail    (!fifo_empty),
      .head     (head),
      .dst_ack  (dst_ack),
      .dst_wr   (dst_wr),
      .pop      (pop),
      .dst_data (dst_data)
   );

   assign st_enable = en_q;
   assign st_halt   = halt_q;
   assign st_active = !fifo_empty;
   assign done      = done_q;

   p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(src_rd) || $rose(dst_wr)) |-> $past(glb_en));
   p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!st_enable && !st_active && !src_rd && !dst_wr));
   p_no_done_abrupt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(en_q && !ctl_wr));
   p_count_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && reg_wr && sel == SEL_COUNT) |=>
      (beats_left == $past(beats_left) || beats_left == $past(beats_left) - CNT_W'(1)));
   p_idle_flushed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !src_rd && !dst_wr) |=> !st_active);
endmodule

// File: tb/tb_dmach_channel.sv
module tb_dmach_channel;
   localparam int CLK_PERIOD = 10;
   localparam int DW    = 8;
   localparam int DEPTH = 4;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic glb_en = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
   logic [CNT_W-1:0] reg_wdata = '0;
   logic st_enable, st_halt, st_active, src_rd, dst_wr, done;
   logic [CNT_W-1:0] beats_left;
   logic src_req = 1'b0, src_ack = 1'b0, dst_ack = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic [DW-1:0] dst_data;

   int checks = 0, errors = 0;
   int src_n = 0, dst_n = 0, done_cnt = 0, halt_rises = 0, hs_viol = 0;
   int src_lat = 0, dst_lat = 0;
   bit dst_hold = 0, req_rand = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmach_channel #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .st_enable(st_enable),
      .st_halt(st_halt), .st_active(st_active), .beats_left(beats_left),
      .src_req(src_req), .src_rd(src_rd), .src_ack(src_ack),
      .src_data(src_data), .dst_wr(dst_wr), .dst_ack(dst_ack),
      .dst_data(dst_data), .done(done)
   );

   function automatic logic [DW-1:0] beat_val(input int n);
      return DW'((n * 29 + 7) ^ (n >> 3));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input int val);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = CNT_W'(val);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_off();
      for (int i = 0; i < 3000 && st_enable; i++) @(negedge clk);
   endtask

   // source responder
   initial begin
      int w;
      w = 0;
      forever begin
         @(negedge clk);
         if (req_rand) src_req = 1'($urandom % 2);
         else          src_req = 1'b1;
         if (src_ack) src_ack = 1'b0;
         else if (src_rd) begin
            if (w <= 0) begin
               src_ack = 1'b1; src_data = beat_val(src_n); src_n++;
               w = int'($urandom % (src_lat + 1));
            end else w--;
         end
      end
   end

   // destination responder, checks order (R2)
   initial begin
      int w;
      w = 0;
      forever begin
         @(negedge clk);
         if (dst_ack) dst_ack = 1'b0;
         else if (dst_wr && !dst_hold) begin
            if (w <= 0) begin
               check(dst_data == beat_val(dst_n), "R2 data order", dst_data, beat_val(dst_n));
               dst_ack = 1'b1; dst_n++;
               w = int'($urandom % (dst_lat + 1));
            end else w--;
         end
      end
   end

   // monitor sampled after responders settle
   initial begin
      logic p_rd, p_sack, p_wr, p_dack, p_halt;
      logic [DW-1:0] p_data;
      p_rd = 0; p_sack = 0; p_wr = 0; p_dack = 0; p_halt = 0; p_data = '0;
      forever begin
         @(negedge clk); #1;
         if (rst_n) begin
            if (done) done_cnt++;
            if (src_rd && !p_rd && p_halt) halt_rises++;
            if (p_rd && !p_sack && !src_rd) hs_viol++;
            if (p_wr && !p_dack && (!dst_wr || dst_data != p_data)) hs_viol++;
         end
         p_rd = src_rd; p_sack = src_ack; p_wr = dst_wr; p_dack = dst_ack;
         p_halt = st_halt; p_data = dst_data;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic run_xfer(input int n, input string req);
      int bs, bd, bdone;
      bs = src_n; bd = dst_n; bdone = done_cnt;
      wr_reg(1'b1, n);
      wr_reg(1'b0, 1);
      wait_off();
      idle(3);
      check(src_n - bs == n, req, src_n - bs, n);
      check(dst_n - bd == n, req, dst_n - bd, n);
      check(done_cnt - bdone == 1, "R8 one-cycle done", done_cnt - bdone, 1);
      check(!st_enable && !st_active, "R8 self disable", st_enable, 0);
   endtask

   initial begin
      int bs, bd, bdone, snap;
      void'($urandom(32'd4242));
      idle(4);
      check(!st_enable && !st_halt && !st_active && !src_rd && !dst_wr && !done,
            "R3 reset state", {st_enable, st_active, src_rd, dst_wr}, 0);
      rst_n = 1'b1;
      idle(2);

      // R1: global enable low
      bs = src_n; bd = dst_n; bdone = done_cnt;
      wr_reg(1'b1, 5);
      wr_reg(1'b0, 1);
      idle(30);
      check(src_n == bs && dst_n == bd && !src_rd, "R1 gated", src_n - bs, 0);
      check(st_enable, "R1 enable readback", st_enable, 1);
      check(done_cnt == bdone, "R1 no done", done_cnt - bdone, 0);
      glb_en = 1'b1;
      wait_off(); idle(3);
      check(src_n - bs == 5 && dst_n - bd == 5, "R1 released", src_n - bs, 5);

      // R2/R8 directed
      run_xfer(6, "R2 beats");
      bs = src_n; bdone = done_cnt;
      wr_reg(1'b1, 0);
      wr_reg(1'b0, 1);
      idle(4);
      check(src_n == bs && done_cnt - bdone == 1 && !st_enable, "R8 zero count",
            done_cnt - bdone, 1);

      // R9: count write while enabled
      bs = src_n; bd = dst_n;
      src_lat = 2; dst_lat = 2;
      wr_reg(1'b1, 8);
      wr_reg(1'b0, 1);
      wr_reg(1'b1, 40);
      wait_off(); idle(3);
      check(src_n - bs == 8, "R9 count locked", src_n - bs, 8);
      check(dst_n - bd == 8, "R9 count locked dst", dst_n - bd, 8);

      // R4/R5/R6: halt, drain, resume
      bs = src_n; bdone = done_cnt; halt_rises = 0;
      src_lat = 1; dst_lat = 3;
      wr_reg(1'b1, 30);
      wr_reg(1'b0, 1);
      idle(8);
      wr_reg(1'b0, 3);
      for (int i = 0; i < 500 && st_active; i++) @(negedge clk);
      idle(20);
      snap = src_n;
      check(!st_active, "R5 drained", st_active, 0);
      check(src_n == dst_n, "R5 all delivered", dst_n, src_n);
      idle(15);
      check(src_n == snap, "R4 no reads while halted", src_n, snap);
      check(halt_rises == 0, "R4 halt blocks src_rd", halt_rises, 0);
      check(st_enable && st_halt, "R6 halted still enabled", st_enable, 1);
      wr_reg(1'b0, 1);
      wait_off(); idle(3);
      check(src_n - bs == 30 && dst_n - bs == 30 - (bs - bs), "R6 resume total",
            src_n - bs, 30);
      check(done_cnt - bdone == 1, "R6 done after resume", done_cnt - bdone, 1);

      // R5/R10: halt then disable loses nothing
      bs = src_n; bdone = done_cnt;
      wr_reg(1'b1, 25);
      wr_reg(1'b0, 1);
      idle(6);
      wr_reg(1'b0, 3);
      for (int i = 0; i < 500 && st_active; i++) @(negedge clk);
      idle(20);
      wr_reg(1'b0, 0);
      idle(10);
      check(src_n == dst_n, "R5 graceful no loss", dst_n, src_n);
      check(done_cnt == bdone, "R10 no done on disable", done_cnt - bdone, 0);
      check(src_n - bs < 25, "R5 stopped early", src_n - bs, 24);

      // R3/R7/R10: full FIFO, abrupt disable
      src_lat = 0; dst_lat = 0; dst_hold = 1;
      bs = src_n; bd = dst_n; bdone = done_cnt;
      wr_reg(1'b1, 20);
      wr_reg(1'b0, 1);
      idle(40);
      check(src_n - bs == DEPTH, "R3 full stops source", src_n - bs, DEPTH);
      check(st_active && !src_rd, "R3 full stall", src_rd, 0);
      wr_reg(1'b0, 0);
      check(!st_enable, "R7 enable clears", st_enable, 0);
      check(st_active, "R7 waits for in-flight", st_active, 1);
      dst_hold = 0;
      idle(20);
      check(!st_active, "R7 fifo discarded", st_active, 1);
      check(dst_n - bd == 1, "R7 only in-flight beat", dst_n - bd, 1);
      check(done_cnt == bdone, "R10 no done abrupt", done_cnt - bdone, 0);
      dst_n = src_n;

      // random mix
      for (int k = 0; k < 16; k++) begin
         src_lat = int'($urandom % 4);
         dst_lat = int'($urandom % 4);
         req_rand = 1'($urandom % 2);
         run_xfer(1 + int'($urandom % 12), "R2 random transfer");
      end
      req_rand = 0;

      check(hs_viol == 0, "R11 handshakes held", hs_viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule